// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

This block sits between a set of peripheral interrupt request lines and a processor core. Each source has its own enable bit. A global enable gates every source. A two-bit level gives each source one of four priorities. The level is built from one bit in a high-priority register and one bit in a low-priority register.

The core raises an instruction-boundary strobe whenever it can accept an interrupt. On that cycle the block chooses the best eligible request. It then issues a one-cycle take pulse together with the winner's source index.

The block keeps a mask of the priority levels whose service routines are still running. This mask lets a routine be preempted only by a strictly more urgent request. A return strobe from the core retires the most urgent routine in progress. Vector address decoding, instruction execution and the peripherals' own flag logic are outside this block.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the enable mask, global enable, both priority registers and the in-service mask are all zero, `takeIrq` is low and `vecIdx` is 0.
- R2: A source's level is {high bit, low bit}. 00 is level 0, the lowest, 01 is level 1, 10 is level 2 and 11 is level 3, the highest. Among eligible requests the highest level wins, whatever the source indices.
- R3: A request is eligible only when its source enable bit is set and the global enable is also set. Clearing either one stops the source from ever being taken.
- R4: When several eligible requests share the highest level, the lowest source index wins.
- R5: A decision is made only in a cycle where `instrBoundary` is high. In the following cycle `takeIrq` is high for exactly that cycle, `vecIdx` holds the winner, and the winner's level bit is set in `inService`.
- R6: While `inService` is non-zero, only a request whose level is strictly above the highest set bit of `inService` is taken. Requests of equal or lower level wait.
- R7: While bit 3 of `inService` is set, no request is taken.
- R8: A `retStrobe` cycle clears the highest set bit of `inService`. If a return and a boundary fall in the same cycle, eligibility is judged against the mask before the clear, and both updates take effect.
- R9: Requests are level-sensitive and are not stored. A request that is low in the boundary cycle is not taken, even if it was high in earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLines | input | NUM_SRC | Request lines, one per source |
| enWr | input | 1 | Write strobe for the per-source enable register |
| enData | input | NUM_SRC | New per-source enable bits |
| gieWr | input | 1 | Write strobe for the global enable |
| gieData | input | 1 | New global enable value |
| hiWr | input | 1 | Write strobe for the priority high-bit register |
| hiData | input | NUM_SRC | New priority high bits |
| loWr | input | 1 | Write strobe for the priority low-bit register |
| loData | input | NUM_SRC | New priority low bits |
| instrBoundary | input | 1 | The core can accept an interrupt in this cycle |
| retStrobe | input | 1 | The core has returned from a service routine |
| takeIrq | output | 1 | One-cycle pulse: an interrupt has been taken |
| vecIdx | output | IDX_W | Index of the taken source |
| inService | output | NUM_LVL | Mask of levels whose routines are in progress |

## Verification
The hardest situation to reach is a return and a boundary in the same cycle while the in-service mask is non-zero. In that case the eligibility ceiling and the mask update disagree for one cycle.

The bench first builds a nested state by taking a level-1 source. It then raises a same-level request and a level-2 request, each in a cycle that also carries `retStrobe`. It checks both the take decision and the mask that results from the combined update.

The preemption chain is reached in a similar way. A taken routine is deliberately not retired, so that later boundaries are judged against a non-empty mask.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // latch the current candidate as the presented vector
  } ctrlStrb_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC = 9,
  parameter int IDX_W   = 4,
  parameter int LVL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqLines,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               gieWr,
  input  logic               gieData,
  input  logic               hiWr,
  input  logic [NUM_SRC-1:0] hiData,
  input  logic               loWr,
  input  logic [NUM_SRC-1:0] loData,
  input  logic               ceilValid,
  input  logic [LVL_W-1:0]   ceilLvl,
  input  ctrlStrb_t          strb,
  output logic               candValid,
  output logic [IDX_W-1:0]   candIdx,
  output logic [LVL_W-1:0]   candLvl,
  output logic [IDX_W-1:0]   vecIdx
);
  logic [NUM_SRC-1:0] enMask, prioHi, prioLo, elig;
  logic               gie;
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
      prioHi <= '0;
      prioLo <= '0;
      gie    <= 1'b0;
      vecIdx <= '0;
    end else begin
      if (enWr)  enMask <= enData;
      if (hiWr)  prioHi <= hiData;
      if (loWr)  prioLo <= loData;
      if (gieWr) gie    <= gieData;
      if (strb.capture) vecIdx <= candIdx;
    end
  end

  // Per-source level and eligibility against the nesting ceiling
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcLvl[i] = {prioHi[i], prioLo[i]};
    assign elig[i]   = gie && enMask[i] && reqLines[i] &&
                       (!ceilValid || (srcLvl[i] > ceilLvl));
  end

  // Highest level wins; descending scan with >= lets low index win ties
  always_comb begin
    candValid = 1'b0;
    candIdx   = '0;
    candLvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!candValid || (srcLvl[i] >= candLvl))) begin
        candValid = 1'b1;
        candIdx   = IDX_W'(i);
        candLvl   = srcLvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_nest_pkg::*;
#(
  parameter int LVL_W   = 2,
  parameter int NUM_LVL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrBoundary,
  input  logic               retStrobe,
  input  logic               candValid,
  input  logic [LVL_W-1:0]   candLvl,
  output logic               ceilValid,
  output logic [LVL_W-1:0]   ceilLvl,
  output ctrlStrb_t          strb,
  output logic               takeIrq,
  output logic [NUM_LVL-1:0] inService
);
  logic               takeNow;
  logic [NUM_LVL-1:0] setMask, clrMask;

  // Highest active level forms the preemption ceiling
  always_comb begin
    ceilLvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (inService[l]) ceilLvl = LVL_W'(l);
    end
  end
  assign ceilValid = |inService;

  assign takeNow     = instrBoundary && candValid;
  assign strb.capture = takeNow;
  assign setMask     = takeNow ? (NUM_LVL'(1) << candLvl) : '0;
  assign clrMask     = (retStrobe && ceilValid) ? (NUM_LVL'(1) << ceilLvl) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inService <= '0;
      takeIrq   <= 1'b0;
    end else begin
      inService <= (inService & ~clrMask) | setMask;
      takeIrq   <= takeNow;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC = 9,
  parameter int NUM_LVL = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LVL_W  = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqLines,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               gieWr,
  input  logic               gieData,
  input  logic               hiWr,
  input  logic [NUM_SRC-1:0] hiData,
  input  logic               loWr,
  input  logic [NUM_SRC-1:0] loData,
  input  logic               instrBoundary,
  input  logic               retStrobe,
  output logic               takeIrq,
  output logic [IDX_W-1:0]   vecIdx,
  output logic [NUM_LVL-1:0] inService
);
  ctrlStrb_t        strb;
  logic             candValid, ceilValid;
  logic [IDX_W-1:0] candIdx;
  logic [LVL_W-1:0] candLvl, ceilLvl;

  irq_datapath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqLines(reqLines),
    .enWr(enWr), .enData(enData), .gieWr(gieWr), .gieData(gieData),
    .hiWr(hiWr), .hiData(hiData), .loWr(loWr), .loData(loData),
    .ceilValid(ceilValid), .ceilLvl(ceilLvl), .strb(strb),
    .candValid(candValid), .candIdx(candIdx), .candLvl(candLvl),
    .vecIdx(vecIdx)
  );

  irq_control #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_ctl (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary),
    .retStrobe(retStrobe), .candValid(candValid), .candLvl(candLvl),
    .ceilValid(ceilValid), .ceilLvl(ceilLvl), .strb(strb),
    .takeIrq(takeIrq), .inService(inService)
  );
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NUM_SRC = 9,
  parameter int NUM_LVL = 4,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqLines,
  input logic               instrBoundary,
  input logic               retStrobe,
  input logic               takeIrq,
  input logic [IDX_W-1:0]   vecIdx,
  input logic [NUM_LVL-1:0] inService
);
  logic [NUM_SRC-1:0] reqQ;
  always_ff @(posedge clk) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= reqLines;
  end

  assert_take_after_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(instrBoundary));

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (int'(vecIdx) < NUM_SRC));

  assert_winner_was_requesting_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq && (int'(vecIdx) < NUM_SRC) |-> reqQ[vecIdx]);

  assert_top_level_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    inService[NUM_LVL-1] && !retStrobe |=> !takeIrq);

  assert_return_clears_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe && !instrBoundary && (inService != '0) |=>
      ($countones(inService) + 1 == $countones($past(inService))));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqLines(reqLines), .instrBoundary(instrBoundary),
  .retStrobe(retStrobe), .takeIrq(takeIrq), .vecIdx(vecIdx), .inService(inService)
);

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/1ps
module sim_irq_nest_ctrl;
  localparam int NS = 9;

  logic          clk = 0, rstN = 0;
  logic [NS-1:0] reqLines = '0, enData = '0, hiData = '0, loData = '0;
  logic          enWr = 0, gieWr = 0, gieData = 0, hiWr = 0, loWr = 0;
  logic          instrBoundary = 0, retStrobe = 0;
  logic          takeIrq;
  logic [3:0]    vecIdx;
  logic [3:0]    inService;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_nest_ctrl u0 (.*);

  // {req, en, hi, lo, expTake, expIdx}
  localparam logic [40:0] VEC [8] = '{
    {9'h001, 9'h1FF, 9'h000, 9'h000, 1'b1, 4'd0},  // R4 single source
    {9'h106, 9'h1FF, 9'h000, 9'h100, 1'b1, 4'd8},  // R2 level beats index
    {9'h0F0, 9'h0E0, 9'h000, 9'h000, 1'b1, 4'd5},  // R3 disabled skipped
    {9'h003, 9'h1FF, 9'h002, 9'h001, 1'b1, 4'd1},  // R2 level 2 over level 1
    {9'h1FF, 9'h1FF, 9'h0C0, 9'h0C0, 1'b1, 4'd6},  // R4 tie at level 3
    {9'h010, 9'h0EF, 9'h000, 9'h000, 1'b0, 4'd0},  // R3 only disabled source
    {9'h000, 9'h1FF, 9'h000, 9'h000, 1'b0, 4'd0},  // R9 nothing pending
    {9'h180, 9'h1FF, 9'h100, 9'h080, 1'b1, 4'd8}   // R2 level 2 over level 1
  };

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [NS-1:0] en, logic [NS-1:0] hi, logic [NS-1:0] lo);
    enWr = 1; enData = en; hiWr = 1; hiData = hi; loWr = 1; loData = lo;
    gieWr = 1; gieData = 1;
    @(negedge clk);
    enWr = 0; hiWr = 0; loWr = 0; gieWr = 0;
  endtask

  // One cycle with the given strobes; outputs sampled at the next negedge
  task automatic step(logic bnd, logic ret);
    instrBoundary = bnd; retStrobe = ret;
    @(negedge clk);
    instrBoundary = 0; retStrobe = 0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 takeIrq", takeIrq, 0);
    check("R1 inService", inService, 0);
    check("R1 vecIdx", vecIdx, 0);
    rstN = 1;
    @(negedge clk);

    // R3 global enable still clear after reset
    enWr = 1; enData = '1; reqLines = 9'h001;
    @(negedge clk); enWr = 0;
    step(1, 0);
    check("R3 global enable off", takeIrq, 0);

    for (int v = 0; v < 8; v++) begin
      cfg(VEC[v][31:23], VEC[v][22:14], VEC[v][13:5]);
      reqLines = VEC[v][40:32];
      step(1, 0);
      check($sformatf("R2/R3/R4 vec %0d take", v), takeIrq, int'(VEC[v][4]));
      if (VEC[v][4]) check($sformatf("R2/R3/R4 vec %0d idx", v), vecIdx, VEC[v][3:0]);
      reqLines = '0;
      step(0, 1);
      check($sformatf("R8 vec %0d cleared", v), inService, 0);
    end

    // R5 no boundary, no decision
    cfg(9'h1FF, 9'h000, 9'h000);
    reqLines = 9'h004;
    step(0, 0);
    check("R5 no boundary", takeIrq, 0);
    step(1, 0);
    check("R5 take pulse", takeIrq, 1);
    check("R5 idx", vecIdx, 2);
    check("R5 mask level0", inService, 4'b0001);
    @(negedge clk);
    check("R5 pulse one cycle", takeIrq, 0);
    reqLines = '0;
    step(0, 1);

    // R6 nesting: src2 level1, src3 level1 blocked, src4 level2 preempts
    cfg(9'h1FF, 9'h010, 9'h00C);
    reqLines = 9'h004;
    step(1, 0);
    check("R6 first take", takeIrq, 1);
    check("R6 mask 0010", inService, 4'b0010);
    reqLines = 9'h008;
    step(1, 0);
    check("R6 equal level waits", takeIrq, 0);
    reqLines = 9'h010;
    step(1, 0);
    check("R6 higher preempts", takeIrq, 1);
    check("R6 idx 4", vecIdx, 4);
    check("R6 mask 0110", inService, 4'b0110);
    reqLines = '0;
    step(0, 1);
    check("R8 clear top", inService, 4'b0010);

    // R8 same-cycle return and boundary, same level: not taken, mask empties
    reqLines = 9'h008;
    step(1, 1);
    check("R8 same level with return", takeIrq, 0);
    check("R8 mask empty", inService, 0);
    // re-enter level1, then level2 request with return
    step(1, 0);
    check("R8 re-enter", inService, 4'b0010);
    reqLines = 9'h010;
    step(1, 1);
    check("R8 higher with return", takeIrq, 1);
    check("R8 mask swap", inService, 4'b0100);
    reqLines = '0;
    step(0, 1);

    // R7 level 3 in service blocks all
    cfg(9'h1FF, 9'h003, 9'h001);
    reqLines = 9'h001;
    step(1, 0);
    check("R7 level3 taken", inService, 4'b1000);
    reqLines = 9'h1FF;
    step(1, 0);
    check("R7 blocked", takeIrq, 0);
    reqLines = '0;
    step(0, 1);
    check("R7 released", inService, 0);

    // R9 request that drops before the boundary
    reqLines = 9'h020;
    @(negedge clk); @(negedge clk);
    reqLines = '0;
    step(1, 0);
    check("R9 not latched", takeIrq, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule